// File: doc/BRIEF.md
# Sync Pulse Classifier and Bus Error Monitor

This block watches a sampled single-wire serial bus on which logic 0 is the dominant level. It measures every dominant pulse in clock ticks and, when the pulse ends, decides whether it is a normal sync, an alarm sync or an error. A cycle timer runs from the last correct sync. How a pulse is judged depends on whether it ends before or after a boundary point in that cycle.

Four sticky error flags record format errors, early syncs, lost syncs and illegal pulses. Each flag has its own interrupt enable. A traffic-enable output tells the surrounding frame logic when it may send and receive. The recovery rule depends on the error: a format error keeps the node synchronized and only waits for an idle gap; an early sync restarts the cycle; a lost sync or an illegal pulse blocks traffic until the next correct sync.

The block also steers the receive path. While the local transmitter is active, and for eight bit times after it stops, the monitored line is the local transmit line rather than the bus, so that echoes are not received. All timing limits are parameters in clock ticks. The boundary is CYC_MIN - SYNN_MAX ticks after the last correct sync.

Top module: `sync_pulse_monitor`

## Requirements
- R1: A dominant pulse of L ticks is a valid sync when SYNA_MIN < L < SYNA_MAX (alarm) or SYNN_MIN < L < SYNN_MAX (normal). The cycle after its recessive edge, sync_o pulses high for one cycle, and alarm_o shows 1 for an alarm sync or 0 for a normal one.
- R2: Before the boundary, a pulse with START_SEQ < L < SYNA_MIN sets the format flag, bit 0. A pulse with L <= START_SEQ changes no flag.
- R3: Before the boundary, any other non-sync pulse with L > START_SEQ sets the illegal flag, bit 3. This includes lengths equal to a window edge.
- R4: After the boundary, and whenever the block is not synchronized, every non-sync pulse sets the illegal flag (bit 3), whatever its length.
- R5: A pulse still dominant past SYNN_MAX ticks sets the illegal flag on its (SYNN_MAX+1)-th dominant tick, without waiting for the pulse to end.
- R6: A valid sync that ends before the boundary is taken as a sync and restarts the cycle. It also sets the early flag, bit 1, and txrx_en_o stays high.
- R7: If no valid sync ends within CYC_MAX ticks of the last one, the lost flag (bit 2) is set on tick CYC_MAX and txrx_en_o drops. txrx_en_o returns only with the next valid sync.
- R8: After an illegal pulse, txrx_en_o is low until the next valid sync.
- R9: A format error, from the classifier or from the fmt_err_i strobe, sets bit 0. It holds txrx_en_o low until IDLE_MIN consecutive recessive ticks have passed. The block stays synchronized throughout.
- R10: Flags are sticky and are cleared by writing 1 to flag_clr_i. irq_o is the OR over all bits of the flag AND its enable.
- R11: While tx_active_i is high, and for 8*BIT_TICKS ticks after it falls, rx_o follows tx_line_i. At all other times rx_o follows bus_rx_i. The classifier watches rx_o.
- R12: After reset, all flags are 0, irq_o is 0 and txrx_en_o is 0 (not synchronized).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_rx_i | input | 1 | Sampled bus line, 0 is dominant |
| tx_active_i | input | 1 | Local transmitter is driving |
| tx_line_i | input | 1 | Local transmit line |
| fmt_err_i | input | 1 | Frame/CRC format error strobe |
| irq_en_i | input | 4 | Interrupt enable per flag |
| flag_clr_i | input | 4 | Write-one-to-clear strobe per flag |
| flags_o | output | 4 | Sticky flags: 0 format, 1 early, 2 lost, 3 illegal |
| irq_o | output | 1 | Interrupt request |
| txrx_en_o | output | 1 | Transmit/receive permitted |
| sync_o | output | 1 | One-cycle strobe on a valid sync |
| alarm_o | output | 1 | Type of the last valid sync, 1 alarm |
| rx_o | output | 1 | Steered receive line |

## Verification
The assertions assume that fmt_err_i is a single-cycle strobe, that flag_clr_i is pulsed for one cycle, and that the bus input changes only between clock edges. The bench drives every input on the falling clock edge, holds each pulse level for a whole number of ticks, and applies clear strobes for one cycle only. Pulse lengths and idle gaps are chosen from the default parameters so that each end edge falls clearly before or after the boundary, or exactly on a counted limit such as CYC_MAX, IDLE_MIN or the echo hold.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int F_FMT   = 0;
  localparam int F_EARLY = 1;
  localparam int F_LOST  = 2;
  localparam int F_ILL   = 3;
  localparam int NFLAG   = 4;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/spm_echo_mux.sv
module spm_echo_mux #(
  parameter int HOLD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_active_i,
  input  logic tx_line_i,
  input  logic bus_i,
  output logic rx_o
);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               hold_q <= '0;
    else if (tx_active_i)      hold_q <= HOLD_V;
    else if (hold_q != '0)     hold_q <= hold_q - 1'b1;
  end

  assign rx_o = (tx_active_i || hold_q != '0) ? tx_line_i : bus_i;
endmodule

// File: rtl/spm_pulse_meter.sv
module spm_pulse_meter #(
  parameter int LIMIT = 20,
  parameter int LW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  output logic          end_o,
  output logic [LW-1:0] len_o,
  output logic          over_o
);
  localparam logic [LW-1:0] SAT = LW'(LIMIT + 1);

  logic          prev_q;
  logic [LW-1:0] len_q, len_n;

  // length including the current dominant tick, saturating past LIMIT
  always_comb begin
    if (prev_q)          len_n = LW'(1);
    else if (len_q == SAT) len_n = SAT;
    else                 len_n = len_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      len_q  <= '0;
    end else begin
      prev_q <= rx_i;
      if (!rx_i) len_q <= len_n;
    end
  end

  assign end_o  = rx_i && !prev_q;
  assign len_o  = len_q;
  assign over_o = !rx_i && (len_n == SAT) && !(!prev_q && len_q == SAT);
endmodule

// File: rtl/spm_sync_tracker.sv
module spm_sync_tracker
  import spm_pkg::*;
#(
  parameter int START_SEQ = 4,
  parameter int SYNA_MIN  = 8,
  parameter int SYNA_MAX  = 12,
  parameter int SYNN_MIN  = 16,
  parameter int SYNN_MAX  = 20,
  parameter int BOUND     = 100,
  parameter int CYC_MAX   = 160,
  parameter int IDLE_MIN  = 12,
  parameter int LW        = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          end_i,
  input  logic [LW-1:0] len_i,
  input  logic          over_i,
  input  logic          fmt_ext_i,
  output flag_vec_t     set_o,
  output logic          sync_o,
  output logic          alarm_o,
  output logic          en_o
);
  localparam int CW = $clog2(CYC_MAX + 1);
  localparam int IW = $clog2(IDLE_MIN + 1);
  localparam logic [LW-1:0] L_ST  = LW'(START_SEQ);
  localparam logic [LW-1:0] L_AMN = LW'(SYNA_MIN);
  localparam logic [LW-1:0] L_AMX = LW'(SYNA_MAX);
  localparam logic [LW-1:0] L_NMN = LW'(SYNN_MIN);
  localparam logic [LW-1:0] L_NMX = LW'(SYNN_MAX);
  localparam logic [CW-1:0] C_BND = CW'(BOUND);
  localparam logic [CW-1:0] C_MAX = CW'(CYC_MAX);
  localparam logic [CW-1:0] C_LST = CW'(CYC_MAX - 1);
  localparam logic [IW-1:0] I_END = IW'(IDLE_MIN - 1);
  localparam logic [IW-1:0] I_SAT = IW'(IDLE_MIN);

  logic          synced_q, sync_q, alarm_q, hold_q;
  logic [CW-1:0] cyc_q;
  logic [IW-1:0] idle_q;

  logic valid_a, valid_n, valid, early;
  logic ev_sync, ev_fmt, ev_ill, ev_lost;

  assign valid_a = (len_i > L_AMN) && (len_i < L_AMX);
  assign valid_n = (len_i > L_NMN) && (len_i < L_NMX);
  assign valid   = valid_a || valid_n;
  assign early   = synced_q && (cyc_q < C_BND);

  assign ev_sync = end_i && valid;
  assign ev_fmt  = fmt_ext_i ||
                   (end_i && !valid && early && len_i > L_ST && len_i < L_AMN);
  // ends beyond SYNN_MAX were already reported by over_i
  assign ev_ill  = over_i ||
                   (end_i && !valid && len_i <= L_NMX &&
                    (!early || (len_i > L_ST && len_i >= L_AMN)));
  assign ev_lost = synced_q && !ev_sync && (cyc_q == C_LST);

  always_comb begin
    set_o          = '0;
    set_o[F_FMT]   = ev_fmt;
    set_o[F_EARLY] = ev_sync && early;
    set_o[F_LOST]  = ev_lost;
    set_o[F_ILL]   = ev_ill;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      synced_q <= 1'b0;
      cyc_q    <= '0;
      sync_q   <= 1'b0;
      alarm_q  <= 1'b0;
    end else begin
      sync_q <= ev_sync;
      if (ev_sync) begin
        synced_q <= 1'b1;
        cyc_q    <= '0;
        alarm_q  <= valid_a;
      end else begin
        if (ev_ill || ev_lost) synced_q <= 1'b0;
        if (cyc_q != C_MAX)    cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  // format recovery: wait for an idle gap of IDLE_MIN recessive ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      idle_q <= '0;
    end else if (ev_fmt) begin
      hold_q <= 1'b1;
      idle_q <= '0;
    end else if (!rx_i) begin
      idle_q <= '0;
    end else begin
      if (idle_q != I_SAT)                 idle_q <= idle_q + 1'b1;
      if (hold_q && idle_q == I_END)       hold_q <= 1'b0;
    end
  end

  assign sync_o  = sync_q;
  assign alarm_o = alarm_q;
  assign en_o    = synced_q && !hold_q;
endmodule

// File: rtl/spm_err_flags.sv
module spm_err_flags
  import spm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  flag_vec_t set_i,
  input  flag_vec_t clr_i,
  input  flag_vec_t en_i,
  output flag_vec_t flags_o,
  output logic      irq_o
);
  flag_vec_t req;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       f_q <= 1'b0;
      else if (set_i[i]) f_q <= 1'b1;
      else if (clr_i[i]) f_q <= 1'b0;
    end
    assign flags_o[i] = f_q;
    assign req[i]     = f_q & en_i[i];
  end

  assign irq_o = |req;
endmodule

// File: rtl/sync_pulse_monitor.sv
module sync_pulse_monitor
  import spm_pkg::*;
#(
  parameter int START_SEQ = 4,
  parameter int SYNA_MIN  = 8,
  parameter int SYNA_MAX  = 12,
  parameter int SYNN_MIN  = 16,
  parameter int SYNN_MAX  = 20,
  parameter int CYC_MIN   = 120,
  parameter int CYC_MAX   = 160,
  parameter int IDLE_MIN  = 12,
  parameter int BIT_TICKS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_rx_i,
  input  logic       tx_active_i,
  input  logic       tx_line_i,
  input  logic       fmt_err_i,
  input  logic [3:0] irq_en_i,
  input  logic [3:0] flag_clr_i,
  output logic [3:0] flags_o,
  output logic       irq_o,
  output logic       txrx_en_o,
  output logic       sync_o,
  output logic       alarm_o,
  output logic       rx_o
);
  localparam int BOUND     = CYC_MIN - SYNN_MAX;
  localparam int ECHO_HOLD = 8 * BIT_TICKS;
  localparam int LW        = $clog2(SYNN_MAX + 2);

  logic          end_w, over_w;
  logic [LW-1:0] len_w;
  flag_vec_t     set_w;

  spm_echo_mux #(.HOLD(ECHO_HOLD)) u_echo (
    .clk_i, .rst_ni, .tx_active_i, .tx_line_i,
    .bus_i(bus_rx_i), .rx_o
  );

  spm_pulse_meter #(.LIMIT(SYNN_MAX), .LW(LW)) u_meter (
    .clk_i, .rst_ni, .rx_i(rx_o),
    .end_o(end_w), .len_o(len_w), .over_o(over_w)
  );

  spm_sync_tracker #(
    .START_SEQ(START_SEQ), .SYNA_MIN(SYNA_MIN), .SYNA_MAX(SYNA_MAX),
    .SYNN_MIN(SYNN_MIN), .SYNN_MAX(SYNN_MAX), .BOUND(BOUND),
    .CYC_MAX(CYC_MAX), .IDLE_MIN(IDLE_MIN), .LW(LW)
  ) u_track (
    .clk_i, .rst_ni, .rx_i(rx_o), .end_i(end_w), .len_i(len_w),
    .over_i(over_w), .fmt_ext_i(fmt_err_i), .set_o(set_w),
    .sync_o, .alarm_o, .en_o(txrx_en_o)
  );

  spm_err_flags u_flags (
    .clk_i, .rst_ni, .set_i(set_w), .clr_i(flag_clr_i),
    .en_i(irq_en_i), .flags_o, .irq_o
  );
endmodule

// File: rtl/spm_checker.sv
module spm_checker
  import spm_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_active_i,
  input logic       tx_line_i,
  input logic [3:0] irq_en_i,
  input logic [3:0] flag_clr_i,
  input logic [3:0] flags_o,
  input logic       irq_o,
  input logic       txrx_en_o,
  input logic       sync_o,
  input logic       rx_o
);
  p_sync_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);

  p_early_is_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_EARLY]) |-> sync_o);

  p_lost_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_LOST]) |-> !txrx_en_o);

  p_illegal_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_ILL]) |-> !txrx_en_o);

  p_format_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_FMT]) |-> !txrx_en_o);

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_o & ~flag_clr_i) != 4'b0) |=>
      ((flags_o & $past(flags_o & ~flag_clr_i)) == $past(flags_o & ~flag_clr_i)));

  p_irq_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((flags_o & irq_en_i) != 4'b0));

  p_echo_steer_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_i |-> (rx_o == tx_line_i));
endmodule

bind sync_pulse_monitor spm_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_active_i(tx_active_i),
  .tx_line_i(tx_line_i), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
  .flags_o(flags_o), .irq_o(irq_o), .txrx_en_o(txrx_en_o),
  .sync_o(sync_o), .rx_o(rx_o)
);

// File: tb/tb_sync_pulse_monitor.sv
`timescale 1ns/1ps
module tb_sync_pulse_monitor;
  localparam int CYC_MAX  = 160;
  localparam int IDLE_MIN = 12;
  localparam int ECHO     = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_rx = 1'b1, tx_act = 1'b0, tx_line = 1'b1, fmt_err = 1'b0;
  logic [3:0] irq_en = '0, clr = '0;
  logic [3:0] flags;
  logic irq, en, sync, alarm, rx;

  int total = 0, bad = 0, ticks = 0;

  always #4 clk = ~clk;

  sync_pulse_monitor dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rx_i(bus_rx), .tx_active_i(tx_act),
    .tx_line_i(tx_line), .fmt_err_i(fmt_err), .irq_en_i(irq_en),
    .flag_clr_i(clr), .flags_o(flags), .irq_o(irq), .txrx_en_o(en),
    .sync_o(sync), .alarm_o(alarm), .rx_o(rx)
  );

  always @(posedge clk) begin
    ticks++;
    if (ticks > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=100000", ticks);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; bus_rx = 1'b1; tx_act = 1'b0; tx_line = 1'b1;
    fmt_err = 1'b0; irq_en = '0; clr = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // dominant for l ticks; returns one half-cycle after the ending edge
  task automatic pulse(int l);
    bus_rx = 1'b0;
    repeat (l) @(negedge clk);
    bus_rx = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 flags", flags, 4'h0);
    chk("R12 irq", irq, 1'b0);
    chk("R12 en", en, 1'b0);
  endtask

  task automatic t_windows();
    do_reset();
    pulse(18);
    chk("R1 normal sync", sync, 1'b1);
    chk("R1 normal type", alarm, 1'b0);
    chk("R1 en after sync", en, 1'b1);
    @(negedge clk);
    chk("R1 strobe one cycle", sync, 1'b0);
    idle(110);
    pulse(10);
    chk("R1 alarm sync", sync, 1'b1);
    chk("R1 alarm type", alarm, 1'b1);
    chk("R1 no flags", flags, 4'h0);
  endtask

  task automatic t_before_boundary();
    do_reset();
    pulse(18);
    idle(5);
    pulse(3);
    chk("R2 short pulse ignored", flags, 4'h0);
    chk("R2 short keeps en", en, 1'b1);
    pulse(6);
    chk("R2 format flag", flags, 4'h1);
    chk("R9 en withheld", en, 1'b0);
    idle(IDLE_MIN - 1);
    chk("R9 still withheld", en, 1'b0);
    idle(1);
    chk("R9 en after idle", en, 1'b1);
    pulse(18);
    chk("R9 stayed synced, early", flags, 4'h3);
    chk("R6 early keeps en", en, 1'b1);
    chk("R6 early is sync", sync, 1'b1);
    do_reset();
    pulse(18);
    idle(5);
    pulse(8);
    chk("R3 window edge illegal", flags, 4'h8);
    chk("R8 en dropped", en, 1'b0);
    pulse(14);
    chk("R3 gap illegal", flags, 4'h8);
    pulse(10);
    chk("R8 en back on sync", en, 1'b1);
    chk("R8 not early when unsynced", flags[1], 1'b0);
  endtask

  task automatic t_after_boundary();
    do_reset();
    pulse(18);
    idle(110);
    pulse(3);
    chk("R4 short illegal", flags, 4'h8);
    chk("R4 en dropped", en, 1'b0);
    clr = 4'hf;
    @(negedge clk);
    clr = '0;
    pulse(6);
    chk("R4 unsynced illegal", flags, 4'h8);
  endtask

  task automatic t_overlong();
    do_reset();
    pulse(18);
    idle(5);
    bus_rx = 1'b0;
    idle(20);
    chk("R5 at limit", flags[3], 1'b0);
    idle(1);
    chk("R5 overlong flagged", flags[3], 1'b1);
    chk("R5 en dropped", en, 1'b0);
    bus_rx = 1'b1;
    idle(2);
  endtask

  task automatic t_lost();
    do_reset();
    pulse(18);
    chk("R7 en on sync", en, 1'b1);
    idle(CYC_MAX - 1);
    chk("R7 not yet lost", flags[2], 1'b0);
    idle(1);
    chk("R7 lost flag", flags[2], 1'b1);
    chk("R7 en dropped", en, 1'b0);
    pulse(18);
    chk("R7 en back", en, 1'b1);
    chk("R7 flag sticky", flags[2], 1'b1);
  endtask

  task automatic t_flags_irq();
    do_reset();
    @(negedge clk);
    fmt_err = 1'b1;
    @(negedge clk);
    fmt_err = 1'b0;
    chk("R9 strobe sets format", flags, 4'h1);
    chk("R10 irq masked", irq, 1'b0);
    irq_en = 4'h1;
    #1;
    chk("R10 irq enabled", irq, 1'b1);
    irq_en = 4'he;
    #1;
    chk("R10 other enables", irq, 1'b0);
    idle(3);
    chk("R10 sticky", flags, 4'h1);
    clr = 4'h1;
    @(negedge clk);
    clr = '0;
    chk("R10 cleared", flags, 4'h0);
  endtask

  task automatic t_echo();
    do_reset();
    tx_act = 1'b1; tx_line = 1'b0; bus_rx = 1'b1;
    #1;
    chk("R11 steered active", rx, 1'b0);
    @(negedge clk);
    tx_act = 1'b0;
    idle(ECHO - 1);
    chk("R11 steered in hold", rx, 1'b0);
    idle(1);
    chk("R11 bus after hold", rx, 1'b1);
    tx_line = 1'b1;
    idle(2);
  endtask

  initial begin
    t_reset();
    t_windows();
    t_before_boundary();
    t_after_boundary();
    t_overlong();
    t_lost();
    t_flags_irq();
    t_echo();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule